// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus, with one clock line and one data line. It gives a host read and write access to a small bank of 8-bit configuration registers. Both lines arrive already synchronized to the system clock. The block drives the data line only through an open-drain enable, so asserting `sda_oe` pulls the line low. The block recognizes its fixed 7-bit device address. It then takes a command byte whose top bit selects one of two accesses: a single-byte access at a 7-bit offset, or a counted block access that starts at offset 0.

Register 0 holds the clock-generator controls, and the block brings them out as ports: four spread-amount select bits, a spread enable, and a bit that sets what the outputs do while powered down. The whole bank also appears on a flat output. To read, the host first writes a command and then issues a repeated start with the read bit set.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, register 0 holds 0x8E and every other register holds 0x00. `spread_en` and `pd_drive_low` are 1 and `sda_oe` is 0.
- R2: The slave acknowledges an address byte of 0xD4 (write) or 0xD5 (read) by pulling SDA low during the ninth clock. Any other address gets no acknowledge, and the slave ignores the rest of that transfer up to the next start.
- R3: A command byte with bit 7 set selects a single-byte access, and bits 6:0 give the offset. The slave acknowledges one following data byte and writes it. A second data byte gets no acknowledge and is discarded. A write to an offset at or above the register count is acknowledged but has no effect.
- R4: A single-byte read (write address, command, repeated start, read address) returns the register at the offset, most significant bit first. After the host's not-acknowledge and stop, SDA is released.
- R5: A command byte with bit 7 clear selects a block access. In a block write, the first byte after the command is a count N. The next N bytes go to offsets 0, 1, 2 and so on. Bytes beyond N get no acknowledge and are not written.
- R6: A block read returns the register count first and then the registers in ascending order from offset 0, for as long as the host acknowledges. Offsets at or above the register count read as 0x00.
- R7: In register 0, bit 3 always reads 1 and bit 0 always reads 0, whatever is written.
- R8: A start or stop at any point aborts the current byte, and the slave releases SDA. Bytes completed before the abort keep their values. After a start, the slave decodes a new address.
- R9: The slave samples SDA on a rising SCL and starts driving SDA only while SCL is low. It detects a start or stop as an SDA edge while SCL is high.
- R10: `spread_sel[i]` is register 0 bit (7-i), so bit 7 is select bit 0. Select code 0000 means 0.8 % down-spread, 0001 means 1.0 %, 0010 means 1.25 %, 0011 means 1.5 % and 0100 means 1.75 %. `spread_en` is bit 1 and `pd_drive_low` is bit 2, where 1 drives the outputs low and 0 leaves them three-state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line (resolved bus value) |
| sda_oe | output | 1 | Open-drain enable, 1 pulls the data line low |
| spread_sel | output | 4 | Spread amount select, index i taken from register 0 bit 7-i |
| spread_en | output | 1 | Spread enable (register 0 bit 1) |
| pd_drive_low | output | 1 | Power-down output mode, 1 = drive low, 0 = three-state |
| cfg_regs | output | 8*NREG | Whole register bank, register i in bits 8i+7:8i |

## Verification
The assertions check on every cycle that the slave only starts pulling SDA low while SCL is low and that SDA is released right after a stop. They also check that the fixed bits of register 0 never change and that a register changes only just after a rising SCL. The bench's scenarios are needed for the rest: address matching, command decoding, counted block writes with not-acknowledge past the count, and the byte order of block reads. Only those scenarios can also show aborts that keep earlier bytes, and that a read at an out-of-range offset returns zero.

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h6A,
  parameter int         NREG     = 4,
  parameter logic [7:0] REG0_RST = 8'h8E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [3:0]        spread_sel,
  output logic              spread_en,
  output logic              pd_drive_low,
  output logic [8*NREG-1:0] cfg_regs
);
  localparam int         IW    = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [7:0] NREG8 = 8'(NREG);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_CMD, S_CNT, S_WDAT, S_RCNT, S_RDAT, S_SKIP
  } st_t;

  st_t        st;
  logic       scl_q, sda_q;
  logic [3:0] bcnt;
  logic [7:0] sh, tx, rem;
  logic [6:0] ptr;
  logic       ack, txm, blk;
  logic [7:0] bank [NREG];

  wire rise    = scl_i & ~scl_q;
  wire fall    = ~scl_i & scl_q;
  wire start_c = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c  = scl_i & scl_q & ~sda_q & sda_i;
  wire [7:0] rxb = {sh[6:0], sda_i};
  wire ptr_ok  = {1'b0, ptr} < NREG8;
  wire [7:0] rd_val = ptr_ok ? bank[ptr[IW-1:0]] : 8'h00;
  wire last_rx = rise & ~txm & (bcnt == 4'd7) & (st != S_IDLE);
  wire wr_en   = last_rx & (st == S_WDAT) & (rem != 8'd0) & ptr_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      bcnt   <= '0;
      sh     <= '0;
      tx     <= '0;
      rem    <= '0;
      ptr    <= '0;
      ack    <= 1'b0;
      txm    <= 1'b0;
      blk    <= 1'b1;
      sda_oe <= 1'b0;
    end else if (start_c) begin
      st     <= S_ADDR;
      bcnt   <= '0;
      txm    <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      txm    <= 1'b0;
      sda_oe <= 1'b0;
    end else if (st != S_IDLE) begin
      if (rise) begin
        if (bcnt < 4'd9) bcnt <= bcnt + 4'd1;
        if (!txm && bcnt < 4'd8) sh <= rxb;
        if (txm && bcnt == 4'd8) begin
          if (sda_i) st <= S_SKIP;
          else if (st == S_RCNT) st <= S_RDAT;
        end
        if (last_rx) begin
          ack <= 1'b0;
          case (st)
            S_ADDR: begin
              if (rxb[7:1] == DEV_ADDR) begin
                ack <= 1'b1;
                if (rxb[0]) begin
                  st <= blk ? S_RCNT : S_RDAT;
                  if (blk) ptr <= '0;
                end else begin
                  st <= S_CMD;
                end
              end else begin
                st <= S_SKIP;
              end
            end
            S_CMD: begin
              ack <= 1'b1;
              blk <= ~rxb[7];
              st  <= rxb[7] ? S_WDAT : S_CNT;
              ptr <= rxb[7] ? rxb[6:0] : 7'd0;
              rem <= 8'd1;
            end
            S_CNT: begin
              ack <= 1'b1;
              rem <= rxb;
              st  <= S_WDAT;
            end
            S_WDAT: begin
              if (rem != 8'd0) begin
                ack <= 1'b1;
                ptr <= ptr + 7'd1;
                rem <= rem - 8'd1;
              end else begin
                st <= S_SKIP;
              end
            end
            default: ;
          endcase
        end
      end else if (fall) begin
        if (bcnt == 4'd9) begin
          bcnt <= '0;
          txm  <= (st == S_RCNT) || (st == S_RDAT);
          if (st == S_RDAT) begin
            tx     <= rd_val;
            ptr    <= ptr + 7'd1;
            sda_oe <= ~rd_val[7];
          end else if (st == S_RCNT) begin
            tx     <= NREG8;
            sda_oe <= ~NREG8[7];
          end else begin
            sda_oe <= 1'b0;
          end
        end else if (bcnt == 4'd8) begin
          sda_oe <= txm ? 1'b0 : ack;
        end else if (txm && bcnt != 4'd0) begin
          tx     <= {tx[6:0], 1'b0};
          sda_oe <= ~tx[6];
        end
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] RST = (g == 0) ? ((REG0_RST | 8'h08) & 8'hFE) : 8'h00;
    always_ff @(posedge clk) begin
      if (!rst_n)
        bank[g] <= RST;
      else if (wr_en && ptr[IW-1:0] == IW'(g))
        bank[g] <= (g == 0) ? ((rxb | 8'h08) & 8'hFE) : rxb;
    end
    assign cfg_regs[g*8 +: 8] = bank[g];
  end

  assign spread_sel   = {bank[0][4], bank[0][5], bank[0][6], bank[0][7]};
  assign spread_en    = bank[0][1];
  assign pd_drive_low = bank[0][2];
endmodule

module smb_cfg_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_i,
  input logic       sda_oe,
  input logic [7:0] reg0
);
  logic scl_p, sda_p;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_i;
      sda_p <= sda_i;
    end
  end
  wire stop_seen = scl_i & scl_p & ~sda_p & sda_i;

  p_oe_on_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_i));

  p_release_on_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !sda_oe);

  p_fixed_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg0[3] && !reg0[0]);

  p_write_after_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg0) |-> ($past(scl_i) && !$past(scl_i, 2)));
endmodule

bind smb_cfg_slave smb_cfg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
  .sda_oe(sda_oe), .reg0(cfg_regs[7:0])
);

// File: tb/sim_smb_cfg_slave.sv
module sim_smb_cfg_slave;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_low = 1'b0;
  logic sda_oe, spread_en, pd_drive_low;
  logic [3:0] spread_sel;
  logic [31:0] cfg_regs;
  wire sda = ~(host_low | sda_oe);

  always #4 clk = ~clk;

  smb_cfg_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe),
    .spread_sel(spread_sel), .spread_en(spread_en),
    .pd_drive_low(pd_drive_low), .cfg_regs(cfg_regs)
  );

  int n_chk = 0, n_err = 0, viol = 0;
  bit done = 1'b0;
  string tq[$];
  logic [31:0] eq[$];
  logic [31:0] aq[$];

  task automatic expect_v(input string tag, input logic [31:0] v);
    tq.push_back(tag); eq.push_back(v);
  endtask
  task automatic observe(input logic [31:0] v);
    aq.push_back(v);
  endtask
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    expect_v(tag, exp); observe(act);
  endtask

  initial forever begin
    @(negedge clk);
    while (aq.size() > 0 && eq.size() > 0) begin
      string t;
      logic [31:0] a, e;
      t = tq.pop_front(); a = aq.pop_front(); e = eq.pop_front();
      n_chk++;
      if (a !== e) begin
        n_err++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && scl && sda_oe) viol++;
    prev_oe = sda_oe;
  end

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask
  task automatic bus_bit(input logic b, output logic r);
    host_low = ~b; wait_h();
    scl = 1'b1; wait_h();
    r = sda; scl = 1'b0; wait_h();
  endtask
  task automatic bus_start();
    host_low = 1'b0; wait_h();
    scl = 1'b1; wait_h();
    host_low = 1'b1; wait_h();
    scl = 1'b0; wait_h();
  endtask
  task automatic bus_stop();
    host_low = 1'b1; wait_h();
    scl = 1'b1; wait_h();
    host_low = 1'b0; wait_h();
  endtask
  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
    bus_bit(1'b1, r);
    ack = ~r;
  endtask
  task automatic rd_byte(input logic nack, output logic [7:0] d);
    logic r;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      bus_bit(1'b1, r);
      d = {d[6:0], r};
    end
    bus_bit(nack, r);
  endtask

  task automatic byte_read(input string tag, input logic [6:0] off, output logic [7:0] d);
    logic a;
    bus_start();
    wr_byte(8'hD4, a); chk({tag, " addr ack"}, 32'(a), 32'd1);
    wr_byte({1'b1, off}, a); chk({tag, " cmd ack"}, 32'(a), 32'd1);
    bus_start();
    wr_byte(8'hD5, a); chk({tag, " read addr ack"}, 32'(a), 32'd1);
    rd_byte(1'b1, d);
    bus_stop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk("R1 bank reset", cfg_regs, 32'h0000008E);
    chk("R1 spread_en reset", 32'(spread_en), 32'd1);
    chk("R1 pd_drive_low reset", 32'(pd_drive_low), 32'd1);
    chk("R1 sda_oe reset", 32'(sda_oe), 32'd0);
    chk("R10 spread_sel reset", 32'(spread_sel), 32'h1);

    byte_read("R2", 7'd0, d);
    chk("R4 read reg0", 32'(d), 32'h8E);
    wait_h();
    chk("R4 sda released", 32'(sda), 32'd1);

    bus_start();
    wr_byte(8'hA8, a); chk("R2 foreign addr nack", 32'(a), 32'd0);
    wr_byte(8'h81, a); chk("R2 ignored cmd", 32'(a), 32'd0);
    wr_byte(8'h55, a); chk("R2 ignored data", 32'(a), 32'd0);
    bus_stop();
    bus_start();
    wr_byte(8'hD6, a); chk("R2 near addr nack", 32'(a), 32'd0);
    bus_stop();
    chk("R2 bank unchanged", cfg_regs, 32'h0000008E);

    bus_start();
    wr_byte(8'hD4, a); chk("R3 addr ack", 32'(a), 32'd1);
    wr_byte(8'h81, a); chk("R3 cmd ack", 32'(a), 32'd1);
    wr_byte(8'h5A, a); chk("R3 data ack", 32'(a), 32'd1);
    wr_byte(8'h33, a); chk("R3 extra byte nack", 32'(a), 32'd0);
    bus_stop();
    chk("R3 reg1 written", cfg_regs, 32'h00005A8E);
    byte_read("R4", 7'd1, d);
    chk("R4 read reg1", 32'(d), 32'h5A);

    bus_start();
    wr_byte(8'hD4, a);
    wr_byte(8'hFF, a);
    wr_byte(8'h55, a); chk("R3 out-of-range ack", 32'(a), 32'd1);
    bus_stop();
    chk("R3 out-of-range no effect", cfg_regs, 32'h00005A8E);

    bus_start();
    wr_byte(8'hD4, a);
    wr_byte(8'h80, a);
    wr_byte(8'h31, a);
    bus_stop();
    chk("R7 reg0 fixed bits", cfg_regs, 32'h00005A38);
    chk("R10 spread_sel map", 32'(spread_sel), 32'hC);
    chk("R10 spread_en", 32'(spread_en), 32'd0);
    chk("R10 pd_drive_low", 32'(pd_drive_low), 32'd0);

    bus_start();
    wr_byte(8'hD4, a);
    wr_byte(8'h00, a); chk("R5 block cmd ack", 32'(a), 32'd1);
    wr_byte(8'h03, a); chk("R5 count ack", 32'(a), 32'd1);
    wr_byte(8'hF7, a); chk("R5 data0 ack", 32'(a), 32'd1);
    wr_byte(8'h11, a);
    wr_byte(8'h22, a); chk("R5 data2 ack", 32'(a), 32'd1);
    wr_byte(8'h44, a); chk("R5 past count nack", 32'(a), 32'd0);
    bus_stop();
    chk("R5 block bank", cfg_regs, 32'h002211FE);

    bus_start();
    wr_byte(8'hD4, a);
    wr_byte(8'h00, a);
    bus_start();
    wr_byte(8'hD5, a); chk("R6 read addr ack", 32'(a), 32'd1);
    rd_byte(1'b0, d); chk("R6 count byte", 32'(d), 32'd4);
    rd_byte(1'b0, d); chk("R6 reg0", 32'(d), 32'hFE);
    rd_byte(1'b0, d); chk("R6 reg1", 32'(d), 32'h11);
    rd_byte(1'b0, d); chk("R6 reg2", 32'(d), 32'h22);
    rd_byte(1'b0, d); chk("R6 reg3", 32'(d), 32'h00);
    rd_byte(1'b1, d); chk("R6 past end zero", 32'(d), 32'h00);
    bus_stop();
    wait_h();
    chk("R6 sda released", 32'(sda), 32'd1);

    bus_start();
    wr_byte(8'hD4, a);
    wr_byte(8'h82, a);
    for (int i = 0; i < 4; i++) bus_bit(1'b1, a);
    bus_stop();
    chk("R8 stop abort keeps bank", cfg_regs, 32'h002211FE);

    bus_start();
    wr_byte(8'hD4, a);
    wr_byte(8'h00, a);
    wr_byte(8'h03, a);
    wr_byte(8'h99, a);
    for (int i = 0; i < 3; i++) bus_bit(1'b0, a);
    bus_start();
    wr_byte(8'hD4, a); chk("R8 new addr after start", 32'(a), 32'd1);
    wr_byte(8'h81, a);
    bus_start();
    wr_byte(8'hD5, a);
    rd_byte(1'b1, d);
    bus_stop();
    chk("R8 reg1 kept after abort", 32'(d), 32'h11);
    chk("R8 earlier byte kept", cfg_regs, 32'h00221198);

    chk("R9 oe only set with scl low", 32'(viol), 32'd0);

    repeat (5) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule